// File: doc/BRIEF.md
# Graphics Command Packet Framer

The framer sits on the 32-bit command port of a 2D graphics engine. It receives a stream of words over a valid/ready handshake. It cuts the stream into whole command packets, using the opcode in the top byte of each packet's first word to find how many parameter words follow. Each packet is held in an internal buffer until its last word arrives. The complete packet is then replayed to the renderer one word per cycle, with a marker on the final word.

Alongside the framing, the block keeps a bank of eight environment registers. Environment opcodes write these registers. Textured primitives patch the texture-page field on the fly. Two of the registers feed a 13-bit status word. Image-transfer opcodes are not forwarded to the renderer. Their position and size words go to a separate transfer engine instead, and the input stays stalled while that engine reports that it is busy.

Top module: `gfx_pkt_framer`

## Requirements
- R1: After reset, environment register i reads (0xE0 + i) in bits 31:24 with all other bits zero. The status word is 0, pkt_valid is 0 and in_ready is 1.
- R2: The packet length is 1 plus a parameter count taken from the opcode (bits 31:24 of the first word). The counts are as follows. Opcodes 0x20-0x2F take 3, 6, 4, 8 for each aligned group of four. Opcodes 0x30-0x3F take 5, 8, 7, 11. Opcodes 0x40-0x47 take 2, 0x48-0x57 take 3 and 0x58-0x5F take 4. Opcode 0x02 takes 2 and 0x80 takes 3. Every other opcode takes 0, except 0xA0 and 0xC0.
- R3: pkt_valid stays low while a packet is still incomplete, including across idle input cycles. in_ready is low for as long as a packet is being emitted.
- R4: A complete packet appears on pkt_data starting the cycle after its last word is accepted. Its words appear in arrival order on consecutive cycles, and pkt_last is high only on the final word.
- R5: A first word whose opcode is 0xE0-0xE7 stores the whole word into environment register (opcode & 7). The packet is still forwarded as a one-word packet.
- R6: When (opcode & 0xF4) == 0x24, bits 8:0 of environment register 1 are replaced by bits 8:0 of packet word 4, and its other bits are kept.
- R7: When (opcode & 0xF4) == 0x34, bits 8:0 of environment register 1 are replaced by bits 8:0 of packet word 5.
- R8: Opcodes 0xA0 (write) and 0xC0 (read) take 2 parameters and are not forwarded. In the cycle after the last word, xfer_start pulses for exactly one cycle with xfer_pos = word 1 and xfer_size = word 2. xfer_read is 1 for 0xC0 and 0 for 0xA0.
- R9: in_ready is low whenever xfer_busy is high.
- R10: Status bits 10:0 equal bits 10:0 of environment register 1. Status bits 12:11 equal bits 1:0 of environment register 6.
- R11: An opcode with a count of 0 (for example 0x00 or 0x65) is forwarded as a one-word packet with pkt_last set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Framer can take a word |
| pkt_valid | output | 1 | Packet word valid to renderer |
| pkt_data | output | 32 | Packet word to renderer |
| pkt_last | output | 1 | Final word of the packet |
| xfer_start | output | 1 | One-cycle image-transfer start pulse |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_busy | input | 1 | Transfer engine owns the stream |
| env_sel | input | 3 | Environment register select |
| env_data | output | 32 | Selected environment register |
| status | output | 13 | Mirrored status bits |

## Verification
The assertions assume that xfer_busy is driven by a well-behaved transfer engine. They also assume that in_valid may rise or fall at any cycle without any need to hold data. The bench raises xfer_busy only while no packet is half received. It changes in_valid and in_data only at falling edges, and it presents a word only after in_ready has been seen high. As a result, every word it offers is accepted on the next rising edge.

// File: rtl/gfx_pkt_pkg.sv
package gfx_pkt_pkg;
    localparam int WORD_W   = 32;
    localparam int OP_W     = 8;
    localparam int CNT_W    = 4;
    localparam int ENV_N    = 8;
    localparam int ENV_IW   = $clog2(ENV_N);
    localparam int TPAGE_W  = 9;
    localparam logic [OP_W-1:0] OP_XFER_WR = 8'hA0;
    localparam logic [OP_W-1:0] OP_XFER_RD = 8'hC0;
    localparam logic [OP_W-1:0] ENV_TAG    = 8'hE0;
endpackage

// File: rtl/gfx_pkt_lenlut.sv
module gfx_pkt_lenlut
    import gfx_pkt_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    output logic [CNT_W-1:0] nparam
);
    always_comb begin
        nparam = '0;
        unique case (op[7:5])
            3'b001: begin
                if (!op[4]) begin
                    case (op[3:2])
                        2'd0: nparam = 4'd3;
                        2'd1: nparam = 4'd6;
                        2'd2: nparam = 4'd4;
                        default: nparam = 4'd8;
                    endcase
                end else begin
                    case (op[3:2])
                        2'd0: nparam = 4'd5;
                        2'd1: nparam = 4'd8;
                        2'd2: nparam = 4'd7;
                        default: nparam = 4'd11;
                    endcase
                end
            end
            3'b010: begin
                if (op[4:3] == 2'b00)      nparam = 4'd2;
                else if (op[4:3] == 2'b11) nparam = 4'd4;
                else                       nparam = 4'd3;
            end
            default: begin
                if (op == 8'h02 || op == OP_XFER_WR || op == OP_XFER_RD) nparam = 4'd2;
                else if (op == 8'h80)                                    nparam = 4'd3;
                else                                                     nparam = 4'd0;
            end
        endcase
    end
endmodule

// File: rtl/gfx_pkt_envbank.sv
module gfx_pkt_envbank
    import gfx_pkt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ENV_IW-1:0]   wr_idx,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                tp_en,
    input  logic [TPAGE_W-1:0]  tp_val,
    input  logic [ENV_IW-1:0]   rd_idx,
    output logic [WORD_W-1:0]   rd_data,
    output logic [12:0]         status
);
    logic [WORD_W-1:0] env_d [ENV_N];
    logic [WORD_W-1:0] env_q [ENV_N];

    always_comb begin
        for (int i = 0; i < ENV_N; i++) env_d[i] = env_q[i];
        if (wr_en) env_d[wr_idx] = wr_data;
        if (tp_en) env_d[1][TPAGE_W-1:0] = tp_val;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENV_N; i++) begin
            if (!rst_n) env_q[i] <= {ENV_TAG + OP_W'(i), {(WORD_W-OP_W){1'b0}}};
            else        env_q[i] <= env_d[i];
        end
    end

    assign rd_data = env_q[rd_idx];
    assign status  = {env_q[6][1:0], env_q[1][10:0]};
endmodule

// File: rtl/gfx_pkt_framer.sv
module gfx_pkt_framer
    import gfx_pkt_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_data,
    output logic               in_ready,
    output logic               pkt_valid,
    output logic [WORD_W-1:0]  pkt_data,
    output logic               pkt_last,
    output logic               xfer_start,
    output logic               xfer_read,
    output logic [WORD_W-1:0]  xfer_pos,
    output logic [WORD_W-1:0]  xfer_size,
    input  logic               xfer_busy,
    input  logic [ENV_IW-1:0]  env_sel,
    output logic [WORD_W-1:0]  env_data,
    output logic [12:0]        status
);
    localparam int IW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                           emit;
        logic [IW-1:0]                  cnt;
        logic [IW-1:0]                  len;
        logic [IW-1:0]                  idx;
        logic [DEPTH-1:0][WORD_W-1:0]   pbuf;
        logic                           xs;
        logic                           xr;
        logic [WORD_W-1:0]              xpos;
        logic [WORD_W-1:0]              xsize;
    } fr_state_t;

    fr_state_t s_d, s_q;

    logic [OP_W-1:0]    op_cur;
    logic [CNT_W-1:0]   nparam;
    logic               env_we, tp_we;
    logic [ENV_IW-1:0]  env_widx;
    logic [TPAGE_W-1:0] tp_val;

    assign op_cur = (s_q.cnt == '0) ? in_data[WORD_W-1 -: OP_W] : s_q.pbuf[0][WORD_W-1 -: OP_W];

    gfx_pkt_lenlut u_lut (.op(op_cur), .nparam(nparam));

    gfx_pkt_envbank u_env (
        .clk(clk), .rst_n(rst_n),
        .wr_en(env_we), .wr_idx(env_widx), .wr_data(in_data),
        .tp_en(tp_we), .tp_val(tp_val),
        .rd_idx(env_sel), .rd_data(env_data), .status(status)
    );

    assign in_ready = !s_q.emit && !xfer_busy;

    always_comb begin
        logic [IW-1:0] plen;
        logic          acc;
        s_d      = s_q;
        s_d.xs   = 1'b0;
        env_we   = 1'b0;
        env_widx = op_cur[ENV_IW-1:0];
        tp_we    = 1'b0;
        tp_val   = '0;
        acc      = in_valid && in_ready;
        plen     = (s_q.cnt == '0) ? IW'(nparam) + IW'(1) : s_q.len;
        if (s_q.emit) begin
            if (s_q.idx == s_q.len - IW'(1)) begin
                s_d.emit = 1'b0;
                s_d.idx  = '0;
            end else begin
                s_d.idx = s_q.idx + IW'(1);
            end
        end else if (acc) begin
            s_d.pbuf[s_q.cnt] = in_data;
            s_d.len           = plen;
            if (s_q.cnt == '0 && op_cur[7:3] == ENV_TAG[7:3]) env_we = 1'b1;
            if (s_q.cnt + IW'(1) == plen) begin
                s_d.cnt = '0;
                if ((op_cur & 8'hF4) == 8'h24) begin
                    tp_we  = 1'b1;
                    tp_val = s_d.pbuf[4][TPAGE_W-1:0];
                end else if ((op_cur & 8'hF4) == 8'h34) begin
                    tp_we  = 1'b1;
                    tp_val = s_d.pbuf[5][TPAGE_W-1:0];
                end
                if (op_cur == OP_XFER_WR || op_cur == OP_XFER_RD) begin
                    s_d.xs    = 1'b1;
                    s_d.xr    = (op_cur == OP_XFER_RD);
                    s_d.xpos  = s_d.pbuf[1];
                    s_d.xsize = s_d.pbuf[2];
                end else begin
                    s_d.emit = 1'b1;
                    s_d.idx  = '0;
                end
            end else begin
                s_d.cnt = s_q.cnt + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pkt_valid  = s_q.emit;
    assign pkt_data   = s_q.pbuf[s_q.idx];
    assign pkt_last   = s_q.emit && (s_q.idx == s_q.len - IW'(1));
    assign xfer_start = s_q.xs;
    assign xfer_read  = s_q.xr;
    assign xfer_pos   = s_q.xpos;
    assign xfer_size  = s_q.xsize;
endmodule

// File: rtl/gfx_pkt_framer_chk.sv
module gfx_pkt_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic pkt_valid,
    input logic pkt_last,
    input logic xfer_start,
    input logic xfer_busy
);
    p_ready_low_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !in_ready);
    p_burst_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last) |=> pkt_valid);
    p_last_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_last |-> pkt_valid);
    p_xfer_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);
    p_xfer_not_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !pkt_valid);
    p_busy_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |-> !in_ready);
endmodule

bind gfx_pkt_framer gfx_pkt_framer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .pkt_valid(pkt_valid),
    .pkt_last(pkt_last), .xfer_start(xfer_start), .xfer_busy(xfer_busy)
);

// File: tb/sim_gfx_pkt_framer.sv
module sim_gfx_pkt_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, pkt_valid, pkt_last, xfer_start, xfer_read;
    logic [31:0] pkt_data, xfer_pos, xfer_size, env_data;
    logic        xfer_busy = 1'b0;
    logic [2:0]  env_sel = '0;
    logic [12:0] status;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gfx_pkt_framer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_last(pkt_last), .xfer_start(xfer_start), .xfer_read(xfer_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size), .xfer_busy(xfer_busy),
        .env_sel(env_sel), .env_data(env_data), .status(status)
    );

    localparam int NV = 15;
    localparam logic [15:0] VEC [NV] = '{
        16'h2003, 16'h2406, 16'h2804, 16'h2C08, 16'h3005, 16'h3408, 16'h3807,
        16'h3C0B, 16'h4002, 16'h4803, 16'h5804, 16'h0202, 16'h8003, 16'h0000,
        16'h6500
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_pkt(input logic [7:0] op, input int n, input logic [31:0] base, input bit gap);
        logic [31:0] w;
        bit xf;
        xf = (op == 8'hA0 || op == 8'hC0);
        for (int i = 0; i <= n; i++) begin
            w = (i == 0) ? {op, base[23:0]} : base + 32'(i);
            @(negedge clk);
            if (i > 0) chk(!pkt_valid, "R3 incomplete", 32'(pkt_valid), 0);
            in_valid = 1'b1;
            in_data  = w;
            chk(in_ready, "R3 ready", 32'(in_ready), 1);
            @(posedge clk);
            if (gap && i < n) begin
                @(negedge clk);
                in_valid = 1'b0;
                chk(!pkt_valid, "R3 gap", 32'(pkt_valid), 0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (xf) begin
            chk(xfer_start, "R8 start", 32'(xfer_start), 1);
            chk(xfer_pos == base + 1, "R8 pos", xfer_pos, base + 1);
            chk(xfer_size == base + 2, "R8 size", xfer_size, base + 2);
            chk(xfer_read == (op == 8'hC0), "R8 dir", 32'(xfer_read), 32'(op == 8'hC0));
            chk(!pkt_valid, "R8 not fwd", 32'(pkt_valid), 0);
            @(negedge clk);
            chk(!xfer_start, "R8 pulse", 32'(xfer_start), 0);
        end else begin
            for (int b = 0; b <= n; b++) begin
                w = (b == 0) ? {op, base[23:0]} : base + 32'(b);
                chk(pkt_valid, "R2 beat valid", 32'(pkt_valid), 1);
                chk(pkt_data == w, "R4 data", pkt_data, w);
                chk(pkt_last == (b == n), "R4 last", 32'(pkt_last), 32'(b == n));
                chk(!in_ready, "R3 ready emit", 32'(in_ready), 0);
                @(negedge clk);
            end
            chk(!pkt_valid, "R2 length", 32'(pkt_valid), 0);
        end
    endtask

    task automatic env_is(input int i, input logic [31:0] exp, input string req);
        env_sel = 3'(i);
        #1;
        chk(env_data == exp, req, env_data, exp);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 8; i++) env_is(i, {8'hE0 + 8'(i), 24'h0}, "R1 env");
        chk(status == 13'h0, "R1 status", 32'(status), 0);
        chk(!pkt_valid, "R1 pkt_valid", 32'(pkt_valid), 0);
        chk(in_ready, "R1 in_ready", 32'(in_ready), 1);

        // R2/R4/R11 table walk
        for (int v = 0; v < NV; v++)
            send_pkt(VEC[v][15:8], int'(VEC[v][7:0]), 32'h1000 * v, (v % 3) == 1);

        // R5/R10 environment writes
        send_pkt(8'hE1, 0, 32'h0005A5, 1'b0);
        env_is(1, 32'hE10005A5, "R5 env1");
        chk(status[10:0] == 11'h5A5, "R10 low", 32'(status), 32'h5A5);
        send_pkt(8'hE6, 0, 32'h000003, 1'b0);
        env_is(6, 32'hE6000003, "R5 env6");
        chk(status[12:11] == 2'd3, "R10 high", 32'(status), 32'h1DA5);

        // R6 flat textured patch from word 4
        send_pkt(8'h24, 6, 32'h100, 1'b0);
        env_is(1, 32'hE1000504, "R6 tpage");
        chk(status[10:0] == 11'h504, "R10 after R6", 32'(status[10:0]), 32'h504);
        // R7 shaded textured patch from word 5
        send_pkt(8'h36, 8, 32'h0, 1'b1);
        env_is(1, 32'hE1000405, "R7 tpage");

        // R8 transfers
        send_pkt(8'hA0, 2, 32'h10000, 1'b0);
        send_pkt(8'hC0, 2, 32'h20000, 1'b1);

        // R9 busy stall
        @(negedge clk);
        xfer_busy = 1'b1;
        #1;
        chk(!in_ready, "R9 busy", 32'(in_ready), 0);
        in_valid = 1'b1;
        in_data  = 32'hE2000077;
        @(negedge clk);
        @(negedge clk);
        env_is(2, 32'hE2000000, "R9 ignored");
        chk(!pkt_valid, "R9 no pkt", 32'(pkt_valid), 0);
        in_valid  = 1'b0;
        xfer_busy = 1'b0;
        #1;
        chk(in_ready, "R9 release", 32'(in_ready), 1);
        send_pkt(8'h00, 0, 32'h0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule